// File: doc/BRIEF.md
# Bridge Event Interrupt Register Bank

This block gathers event pulses from a PCIe-to-AXI bridge into four sticky status groups and drives one interrupt line. The groups are:

- three link events (L2 exit, hot-reset exit, data-link-up exit);
- a 16-bit word of single-error-corrected (SEC) flags, four per buffer RAM;
- a 16-bit word of double-error-detected (DED) flags with the same layout;
- a 32-bit local status word.

Each status bit is set by a rising edge on its input and stays set until software clears it by writing a one. A mask decides whether each bit reaches the interrupt. In the link, SEC and DED groups a mask bit of 1 blocks the event. In the local group a mask bit of 1 lets the event through.

The bank also has two saturating event counters, one for SEC and one for DED. An ECC control word drives error-injection and per-RAM bypass outputs to the buffer RAMs.

Software uses a plain 32-bit register port. A write takes effect at the clock edge that samples `reg_we`. Reads are combinational from `reg_addr`.

Top module: `evt_irq_bank`

## Requirements
- R1: After reset, all of the following hold. Every status bit and both counters read 0. The SEC mask (0x02C) and DED mask (0x034) read 0x0000FFFF. The link word (0x14C) reads 0x00070000. The local mask (0x044) reads 0. The ECC control word (0x038) reads 0x0F000000. `ecc_bypass_o` is 4'hF, `ecc_inject_o` is 0 and `irq_o` is 0.
- R2: A status bit is set at the first clock edge where its input is high after being low. An input held high does not set the bit again after software clears it.
- R3: Writing to a status word clears the bits where the data is 1 and leaves the bits where it is 0. Writing all ones clears every bit. The status words are at these offsets: SEC 0x028, DED 0x030, local 0x040, link bits 2:0 of 0x14C.
- R4: If a rising edge and a clear of the same bit fall in the same cycle, the bit ends up set.
- R5: The SEC and DED status words have four 4-bit fields, one per RAM: tx 3:0, rx 7:4, pcie-to-axi 11:8, axi-to-pcie 15:12. Each mask word sits 4 bytes above its status word. A mask bit of 1 keeps that bit off the interrupt.
- R6: In the local group (status 0x040, mask 0x044), a mask bit of 1 lets that status bit drive the interrupt.
- R7: The link word at 0x14C has status in bits 2:0 (bit 0 L2 exit, bit 1 hot-reset exit, bit 2 data-link-up exit) and blocking masks in bits 18:16. A single write clears the status bits written as 1 and loads bits 18:16 into the masks.
- R8: The SEC counter (0x020) and DED counter (0x024) each add 1 on every clock edge where any input of their group is high, no matter how many inputs are high. They stop at all ones.
- R9: A write to a counter loads the written value, so writing 0 clears it.
- R10: The ECC control word at 0x038 holds the injection bits in 15:0, driven on `ecc_inject_o`, and the bypass bits in 27:24, driven on `ecc_bypass_o`. Its other bits read 0.
- R11: `irq_o` is a register fed by the OR of all unmasked status bits. It goes low one cycle after the last unmasked status bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_evt_i | input | 3 | Link event inputs (L2 exit, hot-reset exit, link-up exit) |
| sec_evt_i | input | 16 | Single-error-corrected event inputs, four per RAM |
| ded_evt_i | input | 16 | Double-error-detected event inputs, four per RAM |
| local_evt_i | input | 32 | Local bridge event inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_o | output | 1 | Combined interrupt |
| ecc_inject_o | output | 16 | ECC error-injection controls |
| ecc_bypass_o | output | 4 | Per-RAM ECC bypass controls |

## Verification
The assertions assume that the event inputs are synchronous to `clk` and that `reg_we` and `reg_addr` hold known values from the end of reset. Under those conditions, edge detection and the sticky, counter and link-word properties can be stated cycle by cycle. The stimulus changes every input 1 ns after a rising edge and holds it for whole cycles. It brings a clear and a new event together only in the one case that tests set-wins priority. It preloads the counter near its top value so that saturation is reached in a few cycles.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

   // Register byte offsets.
   localparam int unsigned OFS_SEC_CNT  = 32'h020;
   localparam int unsigned OFS_DED_CNT  = 32'h024;
   localparam int unsigned OFS_SEC_STS  = 32'h028;
   localparam int unsigned OFS_DED_STS  = 32'h030;
   localparam int unsigned OFS_ECC_CTL  = 32'h038;
   localparam int unsigned OFS_LOC_STS  = 32'h040;
   localparam int unsigned OFS_LOC_MSK  = 32'h044;
   localparam int unsigned OFS_LINK     = 32'h14C;

   // Mask words sit one word above their status words.
   localparam int unsigned MSK_STRIDE   = 4;

   // Bit positions inside shared words.
   localparam int unsigned LINK_MASK_LSB = 16;
   localparam int unsigned ECC_BYP_LSB   = 24;

   // Index 0 is the SEC group, index 1 the DED group.
   localparam int unsigned ERR_STS_OFS [2] = '{OFS_SEC_STS, OFS_DED_STS};
   localparam int unsigned ERR_CNT_OFS [2] = '{OFS_SEC_CNT, OFS_DED_CNT};

   typedef enum logic {
      POL_ENABLE = 1'b0,
      POL_BLOCK  = 1'b1
   } mask_pol_e;

endpackage

// File: rtl/evt_group.sv
module evt_group
   import evt_irq_pkg::*;
#(
   parameter int        W   = 4,
   parameter mask_pol_e POL = POL_BLOCK
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_i,
   input  logic [W-1:0] clr_i,
   input  logic         mask_we,
   input  logic [W-1:0] mask_d,
   output logic [W-1:0] status_o,
   output logic [W-1:0] mask_o,
   output logic         pend_o
);
   // Both polarities reset to "nothing reaches the interrupt".
   localparam logic [W-1:0] MASK_RST = (POL == POL_BLOCK) ? {W{1'b1}} : {W{1'b0}};

   logic [W-1:0] evt_q;
   logic [W-1:0] status_q;
   logic [W-1:0] mask_q;
   logic [W-1:0] rise;
   logic [W-1:0] live;

   assign rise = evt_i & ~evt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_q    <= '0;
         status_q <= '0;
         mask_q   <= MASK_RST;
      end else begin
         evt_q    <= evt_i;
         // A new edge wins over a clear in the same cycle.
         status_q <= (status_q & ~clr_i) | rise;
         if (mask_we) begin
            mask_q <= mask_d;
         end
      end
   end

   generate
      if (POL == POL_BLOCK) begin : g_block
         assign live = ~mask_q;
      end else begin : g_enable
         assign live = mask_q;
      end
   endgenerate

   assign status_o = status_q;
   assign mask_o   = mask_q;
   assign pend_o   = |(status_q & live);
endmodule

// File: rtl/evt_sat_cnt.sv
module evt_sat_cnt #(
   parameter int IN_W  = 4,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IN_W-1:0]  evt_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_d,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_d;
      end else if ((|evt_i) && (cnt_q != CNT_TOP)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/evt_irq_bank.sv
module evt_irq_bank
   import evt_irq_pkg::*;
#(
   parameter  int ADDR_W    = 12,
   parameter  int CNT_W     = 16,
   parameter  int N_RAM     = 4,
   parameter  int RAM_EVT_W = 4,
   parameter  int LOCAL_W   = 32,
   parameter  int LINK_W    = 3,
   localparam int ERR_W     = N_RAM * RAM_EVT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LINK_W-1:0]  link_evt_i,
   input  logic [ERR_W-1:0]   sec_evt_i,
   input  logic [ERR_W-1:0]   ded_evt_i,
   input  logic [LOCAL_W-1:0] local_evt_i,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic               irq_o,
   output logic [ERR_W-1:0]   ecc_inject_o,
   output logic [N_RAM-1:0]   ecc_bypass_o
);
   // Elaboration-time parameter checks.
   generate
      if (ADDR_W < 9 || ADDR_W > 32) begin : g_bad_addr
         $error("evt_irq_bank: ADDR_W must be 9..32");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("evt_irq_bank: CNT_W must be 1..32");
      end
      if (ERR_W < 1 || ERR_W > ECC_BYP_LSB) begin : g_bad_err
         $error("evt_irq_bank: N_RAM*RAM_EVT_W must be 1..24");
      end
      if (N_RAM < 1 || N_RAM > 32 - ECC_BYP_LSB) begin : g_bad_ram
         $error("evt_irq_bank: N_RAM must be 1..8");
      end
      if (LOCAL_W < 1 || LOCAL_W > 32) begin : g_bad_loc
         $error("evt_irq_bank: LOCAL_W must be 1..32");
      end
      if (LINK_W < 1 || LINK_W > LINK_MASK_LSB) begin : g_bad_link
         $error("evt_irq_bank: LINK_W must be 1..16");
      end
   endgenerate

   // Address decode.
   logic hit_link;
   logic hit_loc_sts;
   logic hit_loc_msk;
   logic hit_ecc;

   assign hit_link    = reg_addr == ADDR_W'(OFS_LINK);
   assign hit_loc_sts = reg_addr == ADDR_W'(OFS_LOC_STS);
   assign hit_loc_msk = reg_addr == ADDR_W'(OFS_LOC_MSK);
   assign hit_ecc     = reg_addr == ADDR_W'(OFS_ECC_CTL);

   // SEC and DED groups: identical structure, one generate iteration each.
   logic [ERR_W-1:0] err_evt [2];
   logic [ERR_W-1:0] err_sts [2];
   logic [ERR_W-1:0] err_msk [2];
   logic [CNT_W-1:0] err_cnt [2];
   logic [1:0]       err_pend;
   logic [1:0]       err_hit_sts;
   logic [1:0]       err_hit_msk;
   logic [1:0]       err_hit_cnt;

   assign err_evt[0] = sec_evt_i;
   assign err_evt[1] = ded_evt_i;

   for (genvar g = 0; g < 2; g++) begin : g_err
      logic [ERR_W-1:0] clr;

      assign err_hit_sts[g] = reg_addr == ADDR_W'(ERR_STS_OFS[g]);
      assign err_hit_msk[g] = reg_addr == ADDR_W'(ERR_STS_OFS[g] + MSK_STRIDE);
      assign err_hit_cnt[g] = reg_addr == ADDR_W'(ERR_CNT_OFS[g]);
      assign clr = (reg_we && err_hit_sts[g]) ? reg_wdata[ERR_W-1:0] : '0;

      evt_group #(
         .W   (ERR_W),
         .POL (POL_BLOCK)
      ) u_grp (
         .clk      (clk),
         .rst_n    (rst_n),
         .evt_i    (err_evt[g]),
         .clr_i    (clr),
         .mask_we  (reg_we && err_hit_msk[g]),
         .mask_d   (reg_wdata[ERR_W-1:0]),
         .status_o (err_sts[g]),
         .mask_o   (err_msk[g]),
         .pend_o   (err_pend[g])
      );

      evt_sat_cnt #(
         .IN_W  (ERR_W),
         .CNT_W (CNT_W)
      ) u_cnt (
         .clk    (clk),
         .rst_n  (rst_n),
         .evt_i  (err_evt[g]),
         .load_i (reg_we && err_hit_cnt[g]),
         .load_d (reg_wdata[CNT_W-1:0]),
         .cnt_o  (err_cnt[g])
      );
   end

   // Link group: status and mask share one word.
   logic [LINK_W-1:0] link_sts;
   logic [LINK_W-1:0] link_msk;
   logic              link_pend;
   logic [LINK_W-1:0] link_clr;

   assign link_clr = (reg_we && hit_link) ? reg_wdata[LINK_W-1:0] : '0;

   evt_group #(
      .W   (LINK_W),
      .POL (POL_BLOCK)
   ) u_link (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (link_evt_i),
      .clr_i    (link_clr),
      .mask_we  (reg_we && hit_link),
      .mask_d   (reg_wdata[LINK_MASK_LSB +: LINK_W]),
      .status_o (link_sts),
      .mask_o   (link_msk),
      .pend_o   (link_pend)
   );

   // Local group: a mask bit of 1 enables the event.
   logic [LOCAL_W-1:0] loc_sts;
   logic [LOCAL_W-1:0] loc_msk;
   logic               loc_pend;
   logic [LOCAL_W-1:0] loc_clr;

   assign loc_clr = (reg_we && hit_loc_sts) ? reg_wdata[LOCAL_W-1:0] : '0;

   evt_group #(
      .W   (LOCAL_W),
      .POL (POL_ENABLE)
   ) u_local (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (local_evt_i),
      .clr_i    (loc_clr),
      .mask_we  (reg_we && hit_loc_msk),
      .mask_d   (reg_wdata[LOCAL_W-1:0]),
      .status_o (loc_sts),
      .mask_o   (loc_msk),
      .pend_o   (loc_pend)
   );

   // ECC control word.
   logic [ERR_W-1:0] ecc_inj_q;
   logic [N_RAM-1:0] ecc_byp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ecc_inj_q <= '0;
         ecc_byp_q <= '1;
      end else if (reg_we && hit_ecc) begin
         ecc_inj_q <= reg_wdata[ERR_W-1:0];
         ecc_byp_q <= reg_wdata[ECC_BYP_LSB +: N_RAM];
      end
   end

   assign ecc_inject_o = ecc_inj_q;
   assign ecc_bypass_o = ecc_byp_q;

   // Registered interrupt.
   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else begin
         irq_q <= (|err_pend) | link_pend | loc_pend;
      end
   end

   assign irq_o = irq_q;

   // Read mux.
   always_comb begin
      reg_rdata = '0;
      if (hit_link) begin
         reg_rdata[LINK_W-1:0]               = link_sts;
         reg_rdata[LINK_MASK_LSB +: LINK_W]  = link_msk;
      end
      if (hit_loc_sts) begin
         reg_rdata[LOCAL_W-1:0] = loc_sts;
      end
      if (hit_loc_msk) begin
         reg_rdata[LOCAL_W-1:0] = loc_msk;
      end
      if (hit_ecc) begin
         reg_rdata[ERR_W-1:0]              = ecc_inj_q;
         reg_rdata[ECC_BYP_LSB +: N_RAM]   = ecc_byp_q;
      end
      for (int g = 0; g < 2; g++) begin
         if (err_hit_sts[g]) begin
            reg_rdata[ERR_W-1:0] = err_sts[g];
         end
         if (err_hit_msk[g]) begin
            reg_rdata[ERR_W-1:0] = err_msk[g];
         end
         if (err_hit_cnt[g]) begin
            reg_rdata[CNT_W-1:0] = err_cnt[g];
         end
      end
   end

   // Write bits beyond the widest field are not stored.
   logic unused_wdata;
   assign unused_wdata = ^reg_wdata;
endmodule

// File: rtl/evt_irq_bank_chk.sv
module evt_irq_bank_chk
   import evt_irq_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int CNT_W   = 16,
   parameter int ERR_W   = 16,
   parameter int LOCAL_W = 32,
   parameter int LINK_W  = 3,
   parameter int N_RAM   = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_we,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [31:0]        reg_wdata,
   input logic [ERR_W-1:0]   sec_evt_i,
   input logic [LOCAL_W-1:0] local_evt_i,
   input logic [LINK_W-1:0]  link_evt_i,
   input logic [ERR_W-1:0]   sec_sts,
   input logic [ERR_W-1:0]   ded_sts,
   input logic [LOCAL_W-1:0] loc_sts,
   input logic [LINK_W-1:0]  link_sts,
   input logic [LINK_W-1:0]  link_msk,
   input logic [CNT_W-1:0]   sec_cnt,
   input logic               irq_o,
   input logic [N_RAM-1:0]   ecc_bypass_o
);
   logic             sec_sts_we;
   logic             sec_cnt_we;
   logic             link_we;
   logic [ERR_W-1:0] sec_clr;

   assign sec_sts_we = reg_we && (reg_addr == ADDR_W'(OFS_SEC_STS));
   assign sec_cnt_we = reg_we && (reg_addr == ADDR_W'(OFS_SEC_CNT));
   assign link_we    = reg_we && (reg_addr == ADDR_W'(OFS_LINK));
   assign sec_clr    = sec_sts_we ? reg_wdata[ERR_W-1:0] : '0;

   // Independent edge trackers, one cycle behind the inputs.
   logic [ERR_W-1:0]   sec_prev;
   logic [ERR_W-1:0]   sec_rise_q;
   logic [LOCAL_W-1:0] loc_prev;
   logic [LOCAL_W-1:0] loc_rise_q;
   logic [LINK_W-1:0]  link_prev;
   logic [LINK_W-1:0]  link_rise_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_prev    <= '0;
         sec_rise_q  <= '0;
         loc_prev    <= '0;
         loc_rise_q  <= '0;
         link_prev   <= '0;
         link_rise_q <= '0;
      end else begin
         sec_prev    <= sec_evt_i;
         sec_rise_q  <= sec_evt_i & ~sec_prev;
         loc_prev    <= local_evt_i;
         loc_rise_q  <= local_evt_i & ~loc_prev;
         link_prev   <= link_evt_i;
         link_rise_q <= link_evt_i & ~link_prev;
      end
   end

   // R1: bypass bits leave reset all set.
   p_bypass_rst_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ecc_bypass_o == {N_RAM{1'b1}}));

   // R2: every local rising edge shows up in status one cycle later.
   p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_rise_q != '0) |-> ((loc_rise_q & ~loc_sts) == '0));

   // R4: an SEC edge sets status even when a clear hits the same cycle.
   p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_rise_q != '0) |-> ((sec_rise_q & ~sec_sts) == '0));

   // R3: an SEC status bit only drops when software writes 1 to it.
   p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_sts != '0) |=> (($past(sec_sts) & ~$past(sec_clr) & ~sec_sts) == '0));

   // R8: a saturated counter stays saturated unless reloaded.
   p_cnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((sec_cnt == {CNT_W{1'b1}}) && !sec_cnt_we) |=> (sec_cnt == {CNT_W{1'b1}}));

   // R8: without a reload the counter never goes down.
   p_cnt_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_cnt_we |=> (sec_cnt >= $past(sec_cnt)));

   // R9: writing zero clears the counter.
   p_cnt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_cnt_we && (reg_wdata[CNT_W-1:0] == '0)) |=> (sec_cnt == '0));

   // R7: a link write loads the masks and clears the status it names.
   p_link_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |=> (link_msk == $past(reg_wdata[LINK_MASK_LSB +: LINK_W])));

   p_link_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |=> ((link_sts & $past(reg_wdata[LINK_W-1:0]) & ~link_rise_q) == '0));

   // R11: with nothing pending, the interrupt is low a cycle later.
   p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ((sec_sts == '0) && (ded_sts == '0) && (loc_sts == '0) && (link_sts == '0))
      |=> !irq_o);

   logic unused_chk;
   assign unused_chk = ^reg_wdata;
endmodule

bind evt_irq_bank evt_irq_bank_chk #(
   .ADDR_W  (ADDR_W),
   .CNT_W   (CNT_W),
   .ERR_W   (ERR_W),
   .LOCAL_W (LOCAL_W),
   .LINK_W  (LINK_W),
   .N_RAM   (N_RAM)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_we       (reg_we),
   .reg_addr     (reg_addr),
   .reg_wdata    (reg_wdata),
   .sec_evt_i    (sec_evt_i),
   .local_evt_i  (local_evt_i),
   .link_evt_i   (link_evt_i),
   .sec_sts      (err_sts[0]),
   .ded_sts      (err_sts[1]),
   .loc_sts      (loc_sts),
   .link_sts     (link_sts),
   .link_msk     (link_msk),
   .sec_cnt      (err_cnt[0]),
   .irq_o        (irq_o),
   .ecc_bypass_o (ecc_bypass_o)
);

// File: tb/evt_irq_bank_bench.sv
`timescale 1ns/1ps
module evt_irq_bank_bench;
   localparam logic [11:0] A_SEC_CNT = 12'h020;
   localparam logic [11:0] A_DED_CNT = 12'h024;
   localparam logic [11:0] A_SEC_STS = 12'h028;
   localparam logic [11:0] A_SEC_MSK = 12'h02C;
   localparam logic [11:0] A_DED_STS = 12'h030;
   localparam logic [11:0] A_DED_MSK = 12'h034;
   localparam logic [11:0] A_ECC     = 12'h038;
   localparam logic [11:0] A_LOC_STS = 12'h040;
   localparam logic [11:0] A_LOC_MSK = 12'h044;
   localparam logic [11:0] A_LINK    = 12'h14C;

   localparam int SEL_REG = 0;
   localparam int SEL_IRQ = 1;
   localparam int SEL_INJ = 2;
   localparam int SEL_BYP = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  link_evt = '0;
   logic [15:0] sec_evt = '0;
   logic [15:0] ded_evt = '0;
   logic [31:0] loc_evt = '0;
   logic        reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;
   logic [15:0] inj;
   logic [3:0]  byp;

   always #2.5 clk = ~clk;

   evt_irq_bank u_evt_irq_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .link_evt_i   (link_evt),
      .sec_evt_i    (sec_evt),
      .ded_evt_i    (ded_evt),
      .local_evt_i  (loc_evt),
      .reg_we       (reg_we),
      .reg_addr     (reg_addr),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .irq_o        (irq),
      .ecc_inject_o (inj),
      .ecc_bypass_o (byp)
   );

   typedef struct {
      int          sel;
      logic [31:0] exp;
      string       tag;
   } exp_t;

   exp_t sb_q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   // Monitor: one expectation per cycle, compared at the falling edge.
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t it;
         logic [31:0] act;
         it = sb_q.pop_front();
         case (it.sel)
            SEL_IRQ: act = {31'b0, irq};
            SEL_INJ: act = {16'b0, inj};
            SEL_BYP: act = {28'b0, byp};
            default: act = reg_rdata;
         endcase
         n_cmp++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic push(input int sel, input logic [31:0] e, input string tag);
      exp_t it;
      it.sel = sel;
      it.exp = e;
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      tick();
      reg_we = 1'b1;
      reg_addr = a;
      reg_wdata = d;
      tick();
      reg_we = 1'b0;
   endtask

   task automatic expect_reg(input logic [11:0] a, input logic [31:0] e, input string tag);
      tick();
      reg_addr = a;
      push(SEL_REG, e, tag);
   endtask

   // Waits one edge first so a registered output has caught up.
   task automatic expect_port(input int sel, input logic [31:0] e, input string tag);
      tick();
      push(sel, e, tag);
   endtask

   task automatic expect_port_now(input int sel, input logic [31:0] e, input string tag);
      push(sel, e, tag);
   endtask

   task automatic set_evt(input int grp, input logic [31:0] v);
      case (grp)
         0: sec_evt  = v[15:0];
         1: ded_evt  = v[15:0];
         2: loc_evt  = v;
         default: link_evt = v[2:0];
      endcase
   endtask

   // Input high for exactly n sampling edges.
   task automatic pulse(input int grp, input logic [31:0] v, input int n);
      tick();
      set_evt(grp, v);
      repeat (n) @(posedge clk);
      #1;
      set_evt(grp, 32'h0);
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;

      // R1 reset state
      expect_reg(A_SEC_STS, 32'h0, "R1 sec status");
      expect_reg(A_DED_STS, 32'h0, "R1 ded status");
      expect_reg(A_SEC_MSK, 32'h0000FFFF, "R1 sec mask");
      expect_reg(A_DED_MSK, 32'h0000FFFF, "R1 ded mask");
      expect_reg(A_SEC_CNT, 32'h0, "R1 sec count");
      expect_reg(A_DED_CNT, 32'h0, "R1 ded count");
      expect_reg(A_LINK, 32'h00070000, "R1 link word");
      expect_reg(A_LOC_STS, 32'h0, "R1 local status");
      expect_reg(A_LOC_MSK, 32'h0, "R1 local mask");
      expect_reg(A_ECC, 32'h0F000000, "R1 ecc word");
      expect_port(SEL_BYP, 32'hF, "R1 bypass port");
      expect_port(SEL_INJ, 32'h0, "R1 inject port");
      expect_port(SEL_IRQ, 32'h0, "R1 irq");

      // R2 edge sets sticky SEC bit; R5 stays masked
      pulse(0, 32'h0020, 1);
      expect_reg(A_SEC_STS, 32'h0020, "R2 sec rx field bit");
      expect_reg(A_SEC_CNT, 32'h1, "R8 single pulse count");
      expect_port(SEL_IRQ, 32'h0, "R5 masked sec keeps irq low");

      // R5 unmask rx field
      wr(A_SEC_MSK, 32'h0000FF0F);
      expect_reg(A_SEC_MSK, 32'h0000FF0F, "R5 sec mask readback");
      expect_port(SEL_IRQ, 32'h1, "R5 unmasked sec raises irq");

      // R3 write zero leaves, write one clears; R11 timing
      wr(A_SEC_STS, 32'h0);
      expect_reg(A_SEC_STS, 32'h0020, "R3 zero write keeps status");
      wr(A_SEC_STS, 32'h0020);
      expect_port_now(SEL_IRQ, 32'h1, "R11 irq still high in clear cycle");
      expect_port(SEL_IRQ, 32'h0, "R11 irq low one cycle after clear");
      expect_reg(A_SEC_STS, 32'h0, "R3 one write clears");

      // R2 level held high does not re-set after clear
      tick();
      set_evt(1, 32'h0001);
      wr(A_DED_STS, 32'h0001);
      expect_reg(A_DED_STS, 32'h0, "R2 held level does not re-set");
      tick();
      set_evt(1, 32'h0);
      expect_reg(A_DED_CNT, 32'h4, "R8 count per cycle high");

      // R4 set wins against clear in the same cycle
      tick();
      reg_we = 1'b1;
      reg_addr = A_SEC_STS;
      reg_wdata = 32'h0001;
      sec_evt = 16'h0001;
      tick();
      reg_we = 1'b0;
      sec_evt = 16'h0;
      expect_reg(A_SEC_STS, 32'h0001, "R4 set wins over clear");
      expect_reg(A_SEC_CNT, 32'h2, "R8 count after second event");
      wr(A_SEC_STS, 32'h0001);

      // R8 saturation, R9 load and clear
      wr(A_SEC_CNT, 32'h0000FFFD);
      expect_reg(A_SEC_CNT, 32'h0000FFFD, "R9 counter load");
      pulse(0, 32'h1000, 4);
      expect_reg(A_SEC_CNT, 32'h0000FFFF, "R8 counter saturates");
      expect_reg(A_SEC_STS, 32'h1000, "R2 axi-to-pcie field bit");
      wr(A_SEC_CNT, 32'h0);
      expect_reg(A_SEC_CNT, 32'h0, "R9 zero write clears counter");
      pulse(0, 32'h0303, 2);
      expect_reg(A_SEC_CNT, 32'h2, "R8 many bits count once per cycle");
      expect_reg(A_SEC_STS, 32'h1303, "R2 several sec bits");
      expect_port(SEL_IRQ, 32'h0, "R5 masked fields keep irq low");
      wr(A_SEC_STS, 32'hFFFFFFFF);
      expect_reg(A_SEC_STS, 32'h0, "R3 all ones clears all");

      // R6 local mask enables
      pulse(2, 32'h80000000, 1);
      expect_port(SEL_IRQ, 32'h0, "R6 local mask zero blocks");
      wr(A_LOC_MSK, 32'h80000000);
      expect_port(SEL_IRQ, 32'h1, "R6 local mask one enables");
      expect_reg(A_LOC_STS, 32'h80000000, "R6 local status");
      wr(A_LOC_STS, 32'h80000000);
      expect_port(SEL_IRQ, 32'h0, "R11 local clear drops irq");
      wr(A_LOC_MSK, 32'h0);

      // R7 link word
      pulse(3, 32'h5, 1);
      expect_reg(A_LINK, 32'h00070005, "R7 link status");
      expect_port(SEL_IRQ, 32'h0, "R7 link masked");
      wr(A_LINK, 32'h00020000);
      expect_port(SEL_IRQ, 32'h1, "R7 link unmasked raises irq");
      expect_reg(A_LINK, 32'h00020005, "R7 mask write keeps status");
      wr(A_LINK, 32'h00070005);
      expect_reg(A_LINK, 32'h00070000, "R7 one write clears and masks");
      expect_port(SEL_IRQ, 32'h0, "R7 irq low after combined write");

      // R10 ECC control
      wr(A_ECC, 32'hF5A05A3C);
      expect_reg(A_ECC, 32'h05005A3C, "R10 ecc readback");
      expect_port(SEL_INJ, 32'h5A3C, "R10 inject port");
      expect_port(SEL_BYP, 32'h5, "R10 bypass port");

      // R11 two sources
      wr(A_SEC_MSK, 32'h0000FFF0);
      wr(A_LOC_MSK, 32'h00000001);
      pulse(0, 32'h0004, 1);
      pulse(2, 32'h0001, 1);
      expect_port(SEL_IRQ, 32'h1, "R11 two sources pending");
      wr(A_LOC_STS, 32'h1);
      expect_port(SEL_IRQ, 32'h1, "R11 one source left");
      wr(A_SEC_STS, 32'h4);
      expect_port_now(SEL_IRQ, 32'h1, "R11 high in last clear cycle");
      expect_port(SEL_IRQ, 32'h0, "R11 low after last clear");

      // R5 DED pcie-to-axi field
      pulse(1, 32'h0100, 1);
      expect_port(SEL_IRQ, 32'h0, "R5 ded masked");
      wr(A_DED_MSK, 32'h0000FEFF);
      expect_port(SEL_IRQ, 32'h1, "R5 ded unmasked");
      expect_reg(A_DED_STS, 32'h0100, "R5 ded field bit");
      wr(A_DED_STS, 32'h0100);
      expect_port(SEL_IRQ, 32'h0, "R3 ded clear drops irq");

      repeat (4) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         report();
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
         $finish;
      end
   end
endmodule